// File: doc/BRIEF.md
# Logical Readout with Classical Frame Correction

This block produces the logical result of a three-bit repetition code from one shot of thresholded data-qubit readout. Rather than driving corrective bit-flip pulses onto the qubits, the decoder hands over a frame mask, one bit per data qubit. The block inverts each measured bit whose mask bit is set. Inverting a result read out right after a flip gives the same value as performing the flip, so the outcome matches an actively corrected readout without extra gate time.

The corrected bits then go to a majority vote on the same path. The vote gives the logical bit and a flag that tells a unanimous vote from a two-against-one vote. The corrected bits, the logical bit and that flag are registered. A one-cycle strobe marks each new result, so downstream conditional logic can act on it.

The mask is kept in a register. The register loads on a mask strobe and returns to zero on reset or on a start-of-shot input. A mask that arrives in the same cycle as the measurement is applied at once.

Top module: `logical_frame_readout`

## Requirements
- R1: During and immediately after synchronous reset, `res_vld`, `res_bits`, `res_logic` and `res_split` are all 0, and the held mask is zero.
- R2: `res_vld` is high in the cycle after each cycle where `meas_vld` is high, and low in every other cycle.
- R3: On a result, `res_bits[i]` equals `meas_bits[i] ^ m[i]`, where m is the mask in force and bit 0 is the first data qubit.
- R4: On a result, `res_logic` is 1 exactly when at least two of the three `res_bits` are 1.
- R5: On a result, `res_split` is 1 when the three `res_bits` are not all equal (a 2-to-1 vote) and 0 when they are all 0 or all 1.
- R6: A mask loaded by `mask_vld` stays in force for every later measurement until it is replaced or cleared. With no mask loaded since reset, the bits pass through unchanged.
- R7: When `mask_vld` and `meas_vld` are high in the same cycle, the measurement uses the newly supplied `mask_bits`.
- R8: `shot_clr` zeroes the held mask, and a measurement in the same cycle sees a zero mask. If `mask_vld` is also high, the new mask is loaded and used instead.
- R9: In cycles after which no result is produced, `res_bits`, `res_logic` and `res_split` keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| shot_clr | input | 1 | Start of a new shot; clears the held mask |
| mask_vld | input | 1 | Strobe: `mask_bits` carries a decoder frame mask |
| mask_bits | input | NQ | Frame mask, one bit per data qubit |
| meas_vld | input | 1 | Strobe: `meas_bits` carries one readout shot |
| meas_bits | input | NQ | Thresholded data-qubit results |
| res_vld | output | 1 | One-cycle strobe marking a new result |
| res_bits | output | NQ | Frame-corrected data bits |
| res_logic | output | 1 | Majority of the corrected bits |
| res_split | output | 1 | 1 = 2-to-1 vote, 0 = unanimous |

## Verification
Measurements are sent with no mask, with a mask that persists over several shots, with a mask that arrives in the measurement cycle, and with a start-of-shot clear alone or together with a mask. These cases tell a correct bypass apart from a one-cycle-late mask, and a held mask apart from one that leaks across shots. All eight measurement words are swept against all eight masks. This separates majority from any single bit and unanimous from split votes. Random interleavings of strobes, with idle cycles between them, check that outputs hold and that the valid strobe never appears without a measurement.

// File: rtl/lfr_pkg.sv
package lfr_pkg;

    localparam int unsigned LFR_NQ_DEFAULT = 3;

    typedef enum logic {
        VOTE_UNANIMOUS = 1'b0,
        VOTE_SPLIT     = 1'b1
    } vote_kind_e;

    typedef struct packed {
        logic       logical;
        vote_kind_e kind;
    } vote_t;

    // Turn a count of ones among nq corrected bits into a vote outcome.
    function automatic vote_t vote_from_count(input int ones, input int nq);
        vote_t v;
        v.logical = (2 * ones > nq);
        v.kind    = (ones == 0 || ones == nq) ? VOTE_UNANIMOUS : VOTE_SPLIT;
        return v;
    endfunction

endpackage

// File: rtl/lfr_frame_reg.sv
module lfr_frame_reg #(
    parameter int unsigned NQ = lfr_pkg::LFR_NQ_DEFAULT
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          shot_clr,
    input  logic          mask_vld,
    input  logic [NQ-1:0] mask_bits,
    output logic [NQ-1:0] mask_now
);
    logic [NQ-1:0] mask_q;

    // Mask in force this cycle: a fresh mask wins, then a clear, then the held one.
    always_comb begin
        if (mask_vld)
            mask_now = mask_bits;
        else if (shot_clr)
            mask_now = '0;
        else
            mask_now = mask_q;
    end

    always_ff @(posedge clk) begin
        if (rst)
            mask_q <= '0;
        else
            mask_q <= mask_now;
    end
endmodule

// File: rtl/lfr_frame_apply.sv
module lfr_frame_apply #(
    parameter int unsigned NQ = lfr_pkg::LFR_NQ_DEFAULT
) (
    input  logic [NQ-1:0] raw_bits,
    input  logic [NQ-1:0] mask,
    output logic [NQ-1:0] fixed_bits
);
    for (genvar i = 0; i < NQ; i++) begin : g_flip
        assign fixed_bits[i] = raw_bits[i] ^ mask[i];
    end
endmodule

// File: rtl/lfr_vote.sv
module lfr_vote #(
    parameter int unsigned NQ = lfr_pkg::LFR_NQ_DEFAULT
) (
    input  logic [NQ-1:0]  bits,
    output lfr_pkg::vote_t vote
);
    import lfr_pkg::*;

    localparam int unsigned CW = $clog2(NQ + 1);

    if (NQ == 3) begin : g_three
        always_comb begin
            vote.logical = (bits[0] & bits[1]) | (bits[0] & bits[2]) | (bits[1] & bits[2]);
            vote.kind    = ((&bits) || !(|bits)) ? VOTE_UNANIMOUS : VOTE_SPLIT;
        end
    end else begin : g_count
        logic [CW-1:0] ones;
        always_comb begin
            ones = '0;
            for (int i = 0; i < NQ; i++)
                ones = ones + CW'(bits[i]);
            vote = vote_from_count(int'(ones), int'(NQ));
        end
    end
endmodule

// File: rtl/logical_frame_readout.sv
module logical_frame_readout #(
    parameter int unsigned NQ = lfr_pkg::LFR_NQ_DEFAULT
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          shot_clr,
    input  logic          mask_vld,
    input  logic [NQ-1:0] mask_bits,
    input  logic          meas_vld,
    input  logic [NQ-1:0] meas_bits,
    output logic          res_vld,
    output logic [NQ-1:0] res_bits,
    output logic          res_logic,
    output logic          res_split
);
    import lfr_pkg::*;

    logic [NQ-1:0] mask_now;
    logic [NQ-1:0] fixed_bits;
    vote_t         vote_c;

    lfr_frame_reg #(.NQ(NQ)) u_frame (
        .clk       (clk),
        .rst       (rst),
        .shot_clr  (shot_clr),
        .mask_vld  (mask_vld),
        .mask_bits (mask_bits),
        .mask_now  (mask_now)
    );

    lfr_frame_apply #(.NQ(NQ)) u_apply (
        .raw_bits   (meas_bits),
        .mask       (mask_now),
        .fixed_bits (fixed_bits)
    );

    lfr_vote #(.NQ(NQ)) u_vote (
        .bits (fixed_bits),
        .vote (vote_c)
    );

    // Result stage: strobe every cycle, payload only on a measurement.
    always_ff @(posedge clk) begin
        if (rst) begin
            res_vld   <= 1'b0;
            res_bits  <= '0;
            res_logic <= 1'b0;
            res_split <= 1'b0;
        end else begin
            res_vld <= meas_vld;
            if (meas_vld) begin
                res_bits  <= fixed_bits;
                res_logic <= vote_c.logical;
                res_split <= (vote_c.kind == VOTE_SPLIT);
            end
        end
    end
endmodule

// File: rtl/lfr_checker.sv
module lfr_checker #(
    parameter int unsigned NQ = lfr_pkg::LFR_NQ_DEFAULT
) (
    input logic          clk,
    input logic          rst,
    input logic          shot_clr,
    input logic          mask_vld,
    input logic [NQ-1:0] mask_bits,
    input logic          meas_vld,
    input logic [NQ-1:0] meas_bits,
    input logic          res_vld,
    input logic [NQ-1:0] res_bits,
    input logic          res_logic,
    input logic          res_split
);
    // R1
    reset_clear_chk: assert property (@(posedge clk) rst |=> (!res_vld && res_bits == '0 && !res_logic && !res_split));

    // R2
    vld_follow_chk: assert property (@(posedge clk) disable iff (rst) meas_vld |=> res_vld);

    // R2
    vld_quiet_chk: assert property (@(posedge clk) disable iff (rst) !meas_vld |=> !res_vld);

    // R4
    majority_chk: assert property (@(posedge clk) disable iff (rst)
        res_vld |-> (res_logic == (2 * $countones(res_bits) > NQ)));

    // R5
    split_chk: assert property (@(posedge clk) disable iff (rst)
        res_vld |-> (res_split == (res_bits != '0 && res_bits != '1)));

    // R7
    same_cycle_mask_chk: assert property (@(posedge clk) disable iff (rst)
        (meas_vld && mask_vld) |=> (res_bits == ($past(meas_bits) ^ $past(mask_bits))));

    // R8
    clear_pass_chk: assert property (@(posedge clk) disable iff (rst)
        (meas_vld && shot_clr && !mask_vld) |=> (res_bits == $past(meas_bits)));

    // R9
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        !meas_vld |=> ($stable(res_bits) && $stable(res_logic) && $stable(res_split)));
endmodule

bind logical_frame_readout lfr_checker #(.NQ(NQ)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .shot_clr  (shot_clr),
    .mask_vld  (mask_vld),
    .mask_bits (mask_bits),
    .meas_vld  (meas_vld),
    .meas_bits (meas_bits),
    .res_vld   (res_vld),
    .res_bits  (res_bits),
    .res_logic (res_logic),
    .res_split (res_split)
);

// File: tb/logical_frame_readout_test.sv
module logical_frame_readout_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       shot_clr = 1'b0;
    logic       mask_vld = 1'b0;
    logic [2:0] mask_bits = '0;
    logic       meas_vld = 1'b0;
    logic [2:0] meas_bits = '0;
    logic       res_vld;
    logic [2:0] res_bits;
    logic       res_logic;
    logic       res_split;

    int tests = 0;
    int fails = 0;

    logic [2:0] mdl_mask = '0;
    logic [2:0] exp_bits = '0;
    logic       exp_logic = 1'b0;
    logic       exp_split = 1'b0;

    always #10 clk = ~clk;

    logical_frame_readout uut (
        .clk(clk), .rst(rst), .shot_clr(shot_clr),
        .mask_vld(mask_vld), .mask_bits(mask_bits),
        .meas_vld(meas_vld), .meas_bits(meas_bits),
        .res_vld(res_vld), .res_bits(res_bits),
        .res_logic(res_logic), .res_split(res_split)
    );

    function automatic logic ref_major(input logic [2:0] v);
        return (int'(v[0]) + int'(v[1]) + int'(v[2])) >= 2;
    endfunction

    function automatic logic ref_split(input logic [2:0] v);
        return (v != 3'b000) && (v != 3'b111);
    endfunction

    task automatic check(input logic ok, input string tag, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // One clock: drive at negedge, update the model at the edge, sample 1 ns later.
    task automatic step(input logic xv, input logic [2:0] x, input logic mv,
                        input logic [2:0] m, input logic clr, input string tag);
        logic [2:0] eff;
        @(negedge clk);
        meas_vld = xv; meas_bits = x;
        mask_vld = mv; mask_bits = m; shot_clr = clr;
        @(posedge clk);
        eff = mv ? m : (clr ? 3'b000 : mdl_mask);
        mdl_mask = eff;
        if (xv) begin
            exp_bits  = x ^ eff;
            exp_logic = ref_major(exp_bits);
            exp_split = ref_split(exp_bits);
        end
        #1;
        check(res_vld == xv, "R2 valid strobe", int'(res_vld), int'(xv));
        if (xv) begin
            check(res_bits == exp_bits, {tag, " R3 corrected bits"}, int'(res_bits), int'(exp_bits));
            check(res_logic == exp_logic, "R4 majority", int'(res_logic), int'(exp_logic));
            check(res_split == exp_split, "R5 split flag", int'(res_split), int'(exp_split));
        end else begin
            check(res_bits == exp_bits && res_logic == exp_logic && res_split == exp_split,
                  "R9 hold", int'({res_bits, res_logic, res_split}), int'({exp_bits, exp_logic, exp_split}));
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R1
        check(!res_vld && res_bits == 3'b000 && !res_logic && !res_split, "R1 reset outputs",
              int'({res_vld, res_bits, res_logic, res_split}), 0);
        @(negedge clk);
        rst = 1'b0;
        // R6: no mask yet, pass-through
        step(1, 3'b101, 0, 3'b000, 0, "R6 pass-through");
        step(1, 3'b010, 0, 3'b000, 0, "R6 pass-through");
        // R6: load mask, then persist over shots with gaps
        step(0, 3'b000, 1, 3'b011, 0, "R6 load");
        step(1, 3'b000, 0, 3'b000, 0, "R6 held mask");
        step(0, 3'b000, 0, 3'b000, 0, "R9 idle");
        step(1, 3'b111, 0, 3'b000, 0, "R6 held mask");
        // R7: same-cycle mask
        step(1, 3'b110, 1, 3'b100, 0, "R7 same-cycle mask");
        step(1, 3'b110, 0, 3'b000, 0, "R6 after R7");
        // R8: clear alone with measurement, then clear plus mask
        step(1, 3'b011, 0, 3'b000, 1, "R8 clear");
        step(1, 3'b011, 0, 3'b000, 0, "R8 stays clear");
        step(1, 3'b001, 1, 3'b001, 1, "R8 clear with mask");
        step(1, 3'b100, 0, 3'b000, 0, "R8 mask kept");
        // Exhaustive sweep of measurement words against masks
        for (int mk = 0; mk < 8; mk++) begin
            for (int d = 0; d < 8; d++) begin
                step(1, 3'(d), 1, 3'(mk), 0, "R3 sweep");
            end
        end
        // Random interleaving
        void'($urandom(32'd20240611));
        for (int n = 0; n < 3000; n++) begin
            logic [31:0] r;
            r = $urandom();
            step(r[0], r[3:1], r[4] & r[5], r[8:6], (r[11:9] == 3'b000), "R3 random");
        end
        // R1: reset mid-run clears outputs and mask
        @(negedge clk);
        rst = 1'b1;
        meas_vld = 1'b0; mask_vld = 1'b0; shot_clr = 1'b0;
        @(posedge clk);
        #1;
        check(!res_vld && res_bits == 3'b000 && !res_logic && !res_split, "R1 reset mid-run",
              int'({res_vld, res_bits, res_logic, res_split}), 0);
        @(negedge clk);
        rst = 1'b0;
        mdl_mask = 3'b000;
        step(1, 3'b110, 0, 3'b000, 0, "R1 mask cleared by reset");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        tests++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule